// File: doc/BRIEF.md
# Single-Transfer Bus Master Engine for a DMA Channel

This block carries out one read or one write at a time on a 32-bit pipelined system bus on behalf of a DMA channel. A DMA channel hands it a command through a valid/ready port. The command holds the address, the transfer size (byte, halfword or word), the direction, the write data, a lock request and a protection value. The engine checks that the address is aligned to the size. It then drives an address phase and a data phase, and it returns a one-cycle response pulse with read data or an error flag.

Slaves may insert wait states. They may also answer with a two-cycle ERROR, RETRY or SPLIT response. After RETRY or SPLIT the engine stalls the channel and presents the same transfer again until it completes with OKAY. ERROR ends the command and is reported. Lock and protection are taken from each command. The source-side and destination-side transfers of a stream can therefore carry different attributes.

Top module: `dma_bus_xfer`

## Requirements
- R1: After reset, cmd_ready is 1, bus_trans is IDLE (2'b00), bus_lock is 0 and rsp_valid is 0.
- R2: Only one command is outstanding at a time. cmd_ready stays 0 from the cycle after a command is accepted until its response pulse. rsp_valid is high for one cycle per command.
- R3: A read returns the addressed bytes right-justified in rsp_rdata, with little-endian lanes (the byte at address offset k sits in bits 8k+7:8k). rsp_err is 0. cmd_size and bus_size encode 0=byte, 1=halfword, 2=word.
- R4: For a write, the command data is copied onto every lane of bus_wdata (a byte 4 times, a halfword twice). The slave receives it in the data phase.
- R5: While the slave holds bus_ready low, the address, size and NONSEQ (2'b10) transfer type of a pending address phase stay unchanged. Wait states in the data phase delay the response pulse without repeating the transfer.
- R6: A RETRY (2'b10) or SPLIT (2'b11) response is a two-cycle response. During its first cycle bus_trans is IDLE. After its second cycle the same address, size and direction are presented again, and this repeats until the slave answers OKAY (2'b00).
- R7: An ERROR (2'b01) response ends the command with rsp_valid and rsp_err both 1. No further address phase is issued for that command.
- R8: A command whose address is not aligned to its size, or whose cmd_size is 3, is answered with an error pulse in the cycle after acceptance. No bus cycle is started for it.
- R9: When cmd_lock is 1, bus_lock is high from the address phase through the end of the data phase, including any reissues. When cmd_lock is 0, bus_lock stays low.
- R10: bus_prot equals the command's cmd_prot on every address phase of that command, including reissues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_addr | input | 32 | Byte address |
| cmd_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_wdata | input | 32 | Write data, right-justified |
| cmd_lock | input | 1 | Request a locked transfer |
| cmd_prot | input | 4 | Protection attribute value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an error |
| rsp_rdata | output | 32 | Read data, right-justified |
| bus_addr | output | 32 | Bus address |
| bus_trans | output | 2 | Transfer type, IDLE 00 or NONSEQ 10 |
| bus_write | output | 1 | Bus direction |
| bus_size | output | 3 | Bus transfer size |
| bus_prot | output | 4 | Bus protection attributes |
| bus_lock | output | 1 | Bus lock request |
| bus_wdata | output | 32 | Write data on all lanes |
| bus_rdata | input | 32 | Read data from slave |
| bus_ready | input | 1 | Slave ready |
| bus_resp | input | 2 | OKAY 00, ERROR 01, RETRY 10, SPLIT 11 |

## Verification
The assertions assume a slave that follows the bus rules. It keeps bus_ready high when no data phase is pending. It gives each ERROR, RETRY or SPLIT as a low-ready cycle followed by a high-ready cycle with the same code. It only returns non-OKAY codes while a data phase is pending. The bench's behavioural slave is built to produce exactly this. A test sets its wait-state count, its response code and the number of retries to give before OKAY, so every injected response is well formed. Commands are offered for one cycle only, while the engine is idle.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } xfer_state_e;

    localparam logic [1:0] TRANS_IDLE   = 2'b00;
    localparam logic [1:0] TRANS_NONSEQ = 2'b10;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] RESP_ERROR = 2'b01;
    localparam logic [1:0] RESP_RETRY = 2'b10;
    localparam logic [1:0] RESP_SPLIT = 2'b11;
endpackage

// File: rtl/dma_xfer_align.sv
module dma_xfer_align #(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [1:0]       size,
    output logic             ok
);
    localparam int MAX_SIZE = OFS_W;

    logic [OFS_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < OFS_W; i++) begin
            if (i < int'(size)) mask[i] = 1'b1;
        end
        ok = (int'(size) <= MAX_SIZE) && ((offset & mask) == '0);
    end
endmodule

// File: rtl/dma_xfer_lanes.sv
module dma_xfer_lanes #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]              size,
    input  logic [$clog2(DATA_W/8)-1:0] offset,
    input  logic [DATA_W-1:0]       wdata_in,
    input  logic [DATA_W-1:0]       rdata_bus,
    output logic [DATA_W-1:0]       wdata_bus,
    output logic [DATA_W-1:0]       rdata_out
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic [OFS_W:0]     nbytes;
    logic [DATA_W-1:0]  shifted;
    logic [DATA_W-1:0]  keep;

    assign nbytes = (OFS_W + 1)'(1) << size;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFS_W:0] src;
        assign src = (OFS_W + 1)'(k) & (nbytes - 1'b1);
        assign wdata_bus[8*k +: 8] = wdata_in[8*src[OFS_W-1:0] +: 8];
    end

    always_comb begin
        shifted = rdata_bus >> (8 * int'(offset));
        keep    = '0;
        for (int b = 0; b < LANES; b++) begin
            if (b < int'(nbytes)) keep[8*b +: 8] = 8'hFF;
        end
        rdata_out = shifted & keep;
    end
endmodule

// File: rtl/dma_bus_xfer.sv
module dma_bus_xfer
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PROT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_size,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_lock,
    input  logic [PROT_W-1:0] cmd_prot,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_trans,
    output logic              bus_write,
    output logic [2:0]        bus_size,
    output logic [PROT_W-1:0] bus_prot,
    output logic              bus_lock,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic [1:0]        bus_resp
);
    localparam int OFS_W = $clog2(DATA_W / 8);

    typedef struct packed {
        xfer_state_e        st;
        logic [ADDR_W-1:0]  addr;
        logic [1:0]         size;
        logic               write;
        logic [DATA_W-1:0]  wdata;
        logic               lock;
        logic [PROT_W-1:0]  prot;
        logic               rsp_v;
        logic               rsp_e;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  cmd_ok;
    logic [DATA_W-1:0] rd_aligned;

    dma_xfer_align #(.OFS_W(OFS_W)) i_align (
        .offset (cmd_addr[OFS_W-1:0]),
        .size   (cmd_size),
        .ok     (cmd_ok)
    );

    dma_xfer_lanes #(.DATA_W(DATA_W)) i_lanes (
        .size      (r_q.size),
        .offset    (r_q.addr[OFS_W-1:0]),
        .wdata_in  (r_q.wdata),
        .rdata_bus (bus_rdata),
        .wdata_bus (bus_wdata),
        .rdata_out (rd_aligned)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.rsp_e = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (!cmd_ok) begin
                        r_d.rsp_v = 1'b1;
                        r_d.rsp_e = 1'b1;
                        r_d.rdata = '0;
                    end else begin
                        r_d.st    = ST_ADDR;
                        r_d.addr  = cmd_addr;
                        r_d.size  = cmd_size;
                        r_d.write = cmd_write;
                        r_d.wdata = cmd_wdata;
                        r_d.lock  = cmd_lock;
                        r_d.prot  = cmd_prot;
                    end
                end
            end
            ST_ADDR: begin
                if (bus_ready) r_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (bus_ready) begin
                    unique case (bus_resp)
                        RESP_OKAY: begin
                            r_d.st    = ST_IDLE;
                            r_d.rsp_v = 1'b1;
                            r_d.rdata = r_q.write ? '0 : rd_aligned;
                        end
                        RESP_ERROR: begin
                            r_d.st    = ST_IDLE;
                            r_d.rsp_v = 1'b1;
                            r_d.rsp_e = 1'b1;
                            r_d.rdata = '0;
                        end
                        default: r_d.st = ST_ADDR;
                    endcase
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == ST_IDLE);
    assign rsp_valid = r_q.rsp_v;
    assign rsp_err   = r_q.rsp_e;
    assign rsp_rdata = r_q.rdata;
    assign bus_addr  = r_q.addr;
    assign bus_trans = (r_q.st == ST_ADDR) ? TRANS_NONSEQ : TRANS_IDLE;
    assign bus_write = r_q.write;
    assign bus_size  = {1'b0, r_q.size};
    assign bus_prot  = r_q.prot;
    assign bus_lock  = r_q.lock && (r_q.st != ST_IDLE);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (bus_trans == TRANS_IDLE && !bus_lock && !rsp_valid)) // R1
        else $error("bus active during reset");

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_trans == TRANS_NONSEQ) |-> !cmd_ready) // R2
        else $error("new command accepted while busy");

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_trans == TRANS_NONSEQ && !bus_ready) |=>
        (bus_trans == TRANS_NONSEQ && $stable(bus_addr) && $stable(bus_size))) // R5
        else $error("address phase changed under wait");

    AST_REISSUE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA && bus_ready &&
         (bus_resp == RESP_RETRY || bus_resp == RESP_SPLIT)) |=>
        (bus_trans == TRANS_NONSEQ && $stable(bus_addr) && $stable(bus_size) &&
         $stable(bus_write) && $stable(bus_prot) && !rsp_valid)) // R6
        else $error("retry did not reissue same transfer");

    AST_ERROR_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DATA && bus_ready && bus_resp == RESP_ERROR) |=>
        (rsp_valid && rsp_err && bus_trans == TRANS_IDLE)) // R7
        else $error("error response not reported");

    AST_BUS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_trans == TRANS_NONSEQ) |->
        (bus_size <= 3'd2 &&
         (bus_size == 3'd0 || (bus_size == 3'd1 && !bus_addr[0]) ||
          (bus_size == 3'd2 && bus_addr[1:0] == 2'b00)))) // R8
        else $error("misaligned transfer on bus");

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_trans == TRANS_NONSEQ && bus_lock && bus_ready) |=> bus_lock) // R9
        else $error("lock dropped before data phase");
endmodule

// File: tb/test_dma_bus_xfer.sv
module test_dma_bus_xfer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_size = '0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        cmd_lock = 1'b0;
    logic [3:0]  cmd_prot = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_trans, bus_resp;
    logic        bus_write, bus_lock, bus_ready;
    logic [2:0]  bus_size;
    logic [3:0]  bus_prot;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dma_bus_xfer i_dma_bus_xfer (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_size(cmd_size), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .cmd_lock(cmd_lock), .cmd_prot(cmd_prot),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_write(bus_write),
        .bus_size(bus_size), .bus_prot(bus_prot), .bus_lock(bus_lock),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_resp(bus_resp)
    );

    // behavioural slave
    logic [31:0] mem [16];
    int          cfg_wait = 0;
    logic [1:0]  cfg_resp = 2'b00;
    int          cfg_nretry = 0;
    int          rtry_base = 0;
    int          n_rtry = 0;
    int          n_aph = 0;
    int          attr_bad = 0;
    int          lock_bad = 0;
    int          trans_bad = 0;
    logic [31:0] exp_addr = '0;
    logic [3:0]  exp_prot = '0;
    logic        exp_lock = 1'b0;
    logic [31:0] last_wdata = '0;
    logic        dph = 1'b0;
    int          cnt = 0;
    logic [31:0] a_l = '0;
    logic [2:0]  s_l = '0;
    logic        w_l = 1'b0;
    logic [1:0]  cur;

    always_comb begin
        cur = 2'b00;
        if (cfg_resp == 2'b01) cur = 2'b01;
        else if (cfg_resp != 2'b00 && (n_rtry - rtry_base) < cfg_nretry) cur = cfg_resp;
        bus_ready = 1'b1;
        bus_resp  = 2'b00;
        if (dph) begin
            if (cnt < cfg_wait) bus_ready = 1'b0;
            else if (cur != 2'b00) begin
                bus_resp  = cur;
                bus_ready = (cnt != cfg_wait);
            end
        end
        bus_rdata = dph ? mem[a_l[5:2]] : 32'h0;
    end

    always @(posedge clk) begin
        if (dph) begin
            if (bus_ready) begin
                dph <= 1'b0;
                if (bus_resp == 2'b00 && w_l) begin
                    last_wdata <= bus_wdata;
                    for (int b = 0; b < 4; b++)
                        if (b >= int'(a_l[1:0]) && b < int'(a_l[1:0]) + (1 << s_l))
                            mem[a_l[5:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
                end
                if (bus_resp == 2'b10 || bus_resp == 2'b11) n_rtry <= n_rtry + 1;
            end else cnt <= cnt + 1;
        end
        if (bus_trans == 2'b10 && bus_ready) begin
            dph   <= 1'b1;
            cnt   <= 0;
            a_l   <= bus_addr;
            s_l   <= bus_size;
            w_l   <= bus_write;
            n_aph <= n_aph + 1;
            if (bus_addr != exp_addr || bus_prot != exp_prot) attr_bad <= attr_bad + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if ((bus_trans == 2'b10 || dph) && bus_lock != exp_lock) lock_bad <= lock_bad + 1;
            if (dph && !bus_ready && bus_resp != 2'b00 && bus_trans != 2'b00)
                trans_bad <= trans_bad + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        r_err;
    logic [31:0] r_data;
    logic        busy_low;
    int          aph0;

    task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                         input logic [31:0] wd, input logic lk, input logic [3:0] pr);
        int n = 0;
        exp_addr = a; exp_prot = pr; exp_lock = lk;
        rtry_base = n_rtry;
        aph0 = n_aph;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; cmd_size = sz; cmd_write = wr;
        cmd_wdata = wd; cmd_lock = lk; cmd_prot = pr;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_low = !rsp_valid && !cmd_ready;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        r_err = rsp_err;
        r_data = rsp_rdata;
        chk(rsp_valid, "R2 response arrives", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        chk(!rsp_valid, "R2 single-cycle pulse", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_reset();
        chk(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 32'd1);
        chk(bus_trans == 2'b00, "R1 bus_trans", 32'(bus_trans), 32'd0);
        chk(!bus_lock && !rsp_valid, "R1 lock/rsp", {bus_lock, rsp_valid}, 32'd0);
    endtask

    task automatic t_read_sizes();
        cfg_wait = 0; cfg_resp = 2'b00;
        issue(32'h4, 2'd2, 1'b0, 0, 1'b0, 4'h3);
        chk(!r_err && r_data == 32'h07060504, "R3 word read", r_data, 32'h07060504);
        issue(32'h6, 2'd1, 1'b0, 0, 1'b0, 4'h3);
        chk(!r_err && r_data == 32'h0706, "R3 half read", r_data, 32'h0706);
        issue(32'h7, 2'd0, 1'b0, 0, 1'b0, 4'h3);
        chk(!r_err && r_data == 32'h07, "R3 byte read", r_data, 32'h07);
    endtask

    task automatic t_write();
        issue(32'h9, 2'd0, 1'b1, 32'h5A, 1'b0, 4'h1);
        chk(!r_err && last_wdata == 32'h5A5A5A5A, "R4 byte lanes", last_wdata, 32'h5A5A5A5A);
        issue(32'hE, 2'd1, 1'b1, 32'hBEEF, 1'b0, 4'h1);
        chk(last_wdata == 32'hBEEFBEEF, "R4 half lanes", last_wdata, 32'hBEEFBEEF);
        issue(32'h8, 2'd2, 1'b0, 0, 1'b0, 4'h1);
        chk(r_data == 32'h0B0A5A08, "R4 byte merged", r_data, 32'h0B0A5A08);
        issue(32'hC, 2'd2, 1'b0, 0, 1'b0, 4'h1);
        chk(r_data == 32'hBEEF0D0C, "R4 half merged", r_data, 32'hBEEF0D0C);
    endtask

    task automatic t_wait();
        cfg_wait = 3;
        issue(32'h10, 2'd2, 1'b0, 0, 1'b0, 4'h2);
        chk(r_data == 32'h13121110, "R5 wait read data", r_data, 32'h13121110);
        chk(n_aph - aph0 == 1, "R5 single address phase", n_aph - aph0, 1);
        chk(busy_low, "R2 cmd_ready low while busy", 32'(busy_low), 32'd1);
        cfg_wait = 0;
    endtask

    task automatic t_retry();
        int bad0 = attr_bad;
        cfg_resp = 2'b10; cfg_nretry = 2;
        issue(32'h14, 2'd2, 1'b0, 0, 1'b0, 4'hA);
        chk(!r_err && r_data == 32'h17161514, "R6 retry data", r_data, 32'h17161514);
        chk(n_aph - aph0 == 3, "R6 retry reissues", n_aph - aph0, 3);
        cfg_resp = 2'b11; cfg_nretry = 1; cfg_wait = 1;
        issue(32'h18, 2'd1, 1'b1, 32'h1234, 1'b0, 4'h5);
        chk(!r_err && n_aph - aph0 == 2, "R6 split reissue", n_aph - aph0, 2);
        chk(mem[6][15:0] == 16'h1234, "R6 split write landed", mem[6], 32'h1234);
        chk(attr_bad == bad0, "R10 prot/addr on reissues", attr_bad - bad0, 0);
        chk(trans_bad == 0, "R6 IDLE in first response cycle", trans_bad, 0);
        cfg_resp = 2'b00; cfg_nretry = 0; cfg_wait = 0;
    endtask

    task automatic t_error();
        cfg_resp = 2'b01;
        issue(32'h20, 2'd2, 1'b0, 0, 1'b0, 4'h0);
        chk(r_err == 1'b1, "R7 error flagged", 32'(r_err), 32'd1);
        chk(n_aph - aph0 == 1, "R7 no retry after error", n_aph - aph0, 1);
        cfg_resp = 2'b00;
    endtask

    task automatic t_misalign();
        issue(32'h21, 2'd1, 1'b0, 0, 1'b0, 4'h0);
        chk(r_err && n_aph == aph0, "R8 misaligned half", {r_err, 31'(n_aph - aph0)}, 32'h80000000);
        issue(32'h22, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0, 4'h0);
        chk(r_err && n_aph == aph0, "R8 misaligned word", {r_err, 31'(n_aph - aph0)}, 32'h80000000);
        issue(32'h20, 2'd3, 1'b0, 0, 1'b0, 4'h0);
        chk(r_err && n_aph == aph0, "R8 oversize", {r_err, 31'(n_aph - aph0)}, 32'h80000000);
        chk(mem[8] == 32'h23222120, "R8 no write on reject", mem[8], 32'h23222120);
    endtask

    task automatic t_lock();
        int lb0 = lock_bad;
        cfg_wait = 2; cfg_resp = 2'b10; cfg_nretry = 1;
        issue(32'h24, 2'd2, 1'b0, 0, 1'b1, 4'h7);
        chk(lock_bad == lb0 && !r_err, "R9 lock held source", lock_bad - lb0, 0);
        cfg_resp = 2'b00; cfg_nretry = 0;
        issue(32'h28, 2'd2, 1'b1, 32'hCAFE0001, 1'b0, 4'h6);
        chk(lock_bad == lb0, "R9 lock low destination", lock_bad - lb0, 0);
        cfg_wait = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h03020100 + 32'(i) * 32'h04040404;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_read_sizes();
        t_write();
        t_wait();
        t_retry();
        t_error();
        t_misalign();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule